// File: doc/BRIEF.md
# Chained Sub-Range Table Walker

This block services a miss from a tag-indexed range translation buffer. When a miss arrives, carrying the range ID taken from a pointer tag and the virtual address that missed, the walker reads the matching range-table entry from memory over a simple request/response port. The entry address is formed from a per-context table base plus the ID scaled by the 32-byte entry size. Each entry arrives as four 64-bit words: lower bound, upper bound, translation delta and a control word.

After the fourth word arrives, the walker decides what to do with the entry. If the address lies inside the entry's bounds, it emits a fill for the range buffer. If the entry is also marked as a placeholder, it raises a page-table lookup request in the same cycle. If the address is outside the bounds, the walker follows the entry's next-ID link to another sub-range. When the address is outside the bounds and the entry closes its chain, the walker reports a memory-safety fault. A hop limit turns a looping or over-long chain into a fault, so the walker cannot hang. Only one walk runs at a time, and new misses are held off with a ready signal.

Top module: `rtw_walker`

## Requirements
- R1: Each entry is read as four requests, one word at a time, in the order lower bound, upper bound, delta, control. The request address is table base + (ID << 5) + 8 × word index. A new request is issued only after the response to the previous one.
- R2: The table base is captured when a miss is accepted. Later changes on the table base input do not affect an ongoing walk.
- R3: When lower bound ≤ address < upper bound (unsigned), a one-cycle fill is emitted. It carries that entry's bounds, delta, permissions (control bits 2:0) and ID.
- R4: When the installed entry has its placeholder flag (control bit 3) set, a page-table lookup request carrying the miss address is raised in the same cycle as the fill. It is never raised otherwise.
- R5: When the address is outside the bounds and the chain-end flag (control bit 4) is clear, the walker fetches the entry named by control bits [16 +: ID_W] and applies the same checks to it.
- R6: When the address is outside the bounds and the chain-end flag is set, a one-cycle fault is emitted with the depth flag at 0 and the ID of the entry that failed. No fill is emitted.
- R7: When MAX_HOPS links have already been followed and another link would be needed, a fault is emitted with the depth flag at 1. At most MAX_HOPS+1 entries are read per walk.
- R8: miss_ready is high only while no walk is in progress. It returns high in the same cycle as the fill or fault pulse, and each pulse lasts exactly one cycle.
- R9: After reset, miss_ready is high, and no memory request, fill, lookup request or fault is active.
- R10: A memory request that is not accepted stays valid with the same address until mem_req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker idle, miss accepted |
| miss_id | input | ID_W | Range ID of the miss |
| miss_va | input | 64 | Virtual address that missed |
| table_base | input | 64 | Per-context range-table base |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Byte address of requested word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data word |
| fill_valid | output | 1 | Fill pulse for the range buffer |
| fill_id | output | ID_W | ID of the installed entry |
| fill_base | output | 64 | Lower bound of the installed entry |
| fill_limit | output | 64 | Upper bound (exclusive) |
| fill_delta | output | 64 | Translation delta |
| fill_perm | output | 3 | Permission bits |
| fill_dummy | output | 1 | Installed entry is a placeholder |
| ptw_req_valid | output | 1 | Page-table lookup request pulse |
| ptw_req_va | output | 64 | Address for the page-table lookup |
| fault_valid | output | 1 | Safety fault pulse |
| fault_depth | output | 1 | 1 = hop limit reached, 0 = chain end passed |
| fault_id | output | ID_W | ID of the last entry read |
| fault_va | output | 64 | Faulting address |

## Verification
A fill and a page-table lookup request can occur in the same cycle, because a placeholder entry that covers the address triggers both. The sweeps place placeholder entries at every third ID, and each is reached both directly and through chains of several hops. At every result the bench checks that the lookup request is present exactly when the expected entry is a placeholder, and that the fill fields are correct in that same cycle. A second sweep runs every start/target pair on an unbroken chain, so fills and depth faults meet exactly at the hop limit.

// File: rtl/rtw_pkg.sv
package rtw_pkg;

    localparam int WORD_W      = 64;
    localparam int ENTRY_SHIFT = 5;
    localparam int BEAT_SHIFT  = 3;
    localparam int NUM_BEATS   = 4;
    localparam int PERM_W      = 3;
    localparam int DUMMY_BIT   = 3;
    localparam int LAST_BIT    = 4;
    localparam int NEXT_LSB    = 16;

    typedef logic [WORD_W-1:0] word_t;

    // word order inside an entry: lower, upper, delta, control
    typedef struct packed {
        word_t lower;
        word_t upper;
        word_t delta;
        word_t ctrl;
    } rt_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_RSP,
        ST_JUDGE
    } walk_state_e;

    typedef enum logic [1:0] {
        VD_INSTALL,
        VD_FOLLOW,
        VD_BOUNDS,
        VD_DEPTH
    } verdict_e;

    function automatic logic covers(rt_entry_t e, word_t va);
        return (e.lower <= va) && (va < e.upper);
    endfunction

    function automatic logic [PERM_W-1:0] perm_of(word_t c);
        return c[PERM_W-1:0];
    endfunction

endpackage

// File: rtl/rtw_addr_gen.sv
module rtw_addr_gen
    import rtw_pkg::*;
#(
    parameter int ID_W = 6
) (
    input  word_t           tbl_base,
    input  logic [ID_W-1:0] id,
    input  logic [1:0]      beat,
    output word_t           addr
);
    word_t id_off;
    word_t beat_off;

    assign id_off   = word_t'(id) << ENTRY_SHIFT;
    assign beat_off = word_t'(beat) << BEAT_SHIFT;
    assign addr     = tbl_base + id_off + beat_off;

endmodule

// File: rtl/rtw_beat_collect.sv
module rtw_beat_collect
    import rtw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] beat,
    input  word_t      data,
    output rt_entry_t  entry
);
    word_t words [NUM_BEATS];

    for (genvar b = 0; b < NUM_BEATS; b++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[b] <= '0;
            end else if (wr_en && beat == 2'(b)) begin
                words[b] <= data;
            end
        end
    end

    assign entry.lower = words[0];
    assign entry.upper = words[1];
    assign entry.delta = words[2];
    assign entry.ctrl  = words[3];

endmodule

// File: rtl/rtw_judge.sv
module rtw_judge
    import rtw_pkg::*;
#(
    parameter int ID_W     = 6,
    parameter int MAX_HOPS = 16,
    parameter int HOP_W    = 5
) (
    input  rt_entry_t       ent,
    input  word_t           va,
    input  logic [HOP_W-1:0] hops,
    output verdict_e        verdict,
    output logic [ID_W-1:0] next_id
);
    always_comb begin
        next_id = ent.ctrl[NEXT_LSB +: ID_W];
        if (covers(ent, va)) begin
            verdict = VD_INSTALL;
        end else if (ent.ctrl[LAST_BIT]) begin
            verdict = VD_BOUNDS;
        end else if (hops == HOP_W'(MAX_HOPS)) begin
            verdict = VD_DEPTH;
        end else begin
            verdict = VD_FOLLOW;
        end
    end

endmodule

// File: rtl/rtw_walker.sv
module rtw_walker
    import rtw_pkg::*;
#(
    parameter int ID_W     = 6,
    parameter int MAX_HOPS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                miss_valid,
    output logic                miss_ready,
    input  logic [ID_W-1:0]     miss_id,
    input  logic [WORD_W-1:0]   miss_va,
    input  logic [WORD_W-1:0]   table_base,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [WORD_W-1:0]   mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [WORD_W-1:0]   mem_rsp_data,
    output logic                fill_valid,
    output logic [ID_W-1:0]     fill_id,
    output logic [WORD_W-1:0]   fill_base,
    output logic [WORD_W-1:0]   fill_limit,
    output logic [WORD_W-1:0]   fill_delta,
    output logic [PERM_W-1:0]   fill_perm,
    output logic                fill_dummy,
    output logic                ptw_req_valid,
    output logic [WORD_W-1:0]   ptw_req_va,
    output logic                fault_valid,
    output logic                fault_depth,
    output logic [ID_W-1:0]     fault_id,
    output logic [WORD_W-1:0]   fault_va
);
    localparam int HOP_W = $clog2(MAX_HOPS + 1);

    walk_state_e      state_q;
    logic [ID_W-1:0]  cur_id_q;
    word_t            va_q;
    word_t            base_q;
    logic [1:0]       beat_q;
    logic [HOP_W-1:0] hop_q;

    rt_entry_t        entry;
    verdict_e         verdict;
    logic [ID_W-1:0]  next_id;
    logic             rsp_take;

    assign miss_ready    = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_REQ);
    assign rsp_take      = (state_q == ST_RSP) && mem_rsp_valid;

    rtw_addr_gen #(.ID_W(ID_W)) u_addr (
        .tbl_base (base_q),
        .id       (cur_id_q),
        .beat     (beat_q),
        .addr     (mem_req_addr)
    );

    rtw_beat_collect u_collect (
        .clk   (clk),
        .rst   (rst),
        .wr_en (rsp_take),
        .beat  (beat_q),
        .data  (mem_rsp_data),
        .entry (entry)
    );

    rtw_judge #(.ID_W(ID_W), .MAX_HOPS(MAX_HOPS), .HOP_W(HOP_W)) u_judge (
        .ent     (entry),
        .va      (va_q),
        .hops    (hop_q),
        .verdict (verdict),
        .next_id (next_id)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            cur_id_q      <= '0;
            va_q          <= '0;
            base_q        <= '0;
            beat_q        <= '0;
            hop_q         <= '0;
            fill_valid    <= 1'b0;
            fill_id       <= '0;
            fill_base     <= '0;
            fill_limit    <= '0;
            fill_delta    <= '0;
            fill_perm     <= '0;
            fill_dummy    <= 1'b0;
            ptw_req_valid <= 1'b0;
            ptw_req_va    <= '0;
            fault_valid   <= 1'b0;
            fault_depth   <= 1'b0;
            fault_id      <= '0;
            fault_va      <= '0;
        end else begin
            fill_valid    <= 1'b0;
            ptw_req_valid <= 1'b0;
            fault_valid   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (miss_valid) begin
                        cur_id_q <= miss_id;
                        va_q     <= miss_va;
                        base_q   <= table_base;
                        beat_q   <= '0;
                        hop_q    <= '0;
                        state_q  <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) state_q <= ST_RSP;
                end
                ST_RSP: begin
                    if (mem_rsp_valid) begin
                        if (beat_q == 2'(NUM_BEATS - 1)) begin
                            state_q <= ST_JUDGE;
                        end else begin
                            beat_q  <= beat_q + 2'd1;
                            state_q <= ST_REQ;
                        end
                    end
                end
                ST_JUDGE: begin
                    unique case (verdict)
                        VD_INSTALL: begin
                            fill_valid    <= 1'b1;
                            fill_id       <= cur_id_q;
                            fill_base     <= entry.lower;
                            fill_limit    <= entry.upper;
                            fill_delta    <= entry.delta;
                            fill_perm     <= perm_of(entry.ctrl);
                            fill_dummy    <= entry.ctrl[DUMMY_BIT];
                            ptw_req_valid <= entry.ctrl[DUMMY_BIT];
                            ptw_req_va    <= va_q;
                            state_q       <= ST_IDLE;
                        end
                        VD_FOLLOW: begin
                            cur_id_q <= next_id;
                            hop_q    <= hop_q + 1'b1;
                            beat_q   <= '0;
                            state_q  <= ST_REQ;
                        end
                        default: begin
                            fault_valid <= 1'b1;
                            fault_depth <= (verdict == VD_DEPTH);
                            fault_id    <= cur_id_q;
                            fault_va    <= va_q;
                            state_q     <= ST_IDLE;
                        end
                    endcase
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R4
    ptw_pair_chk: assert property (@(posedge clk) disable iff (rst)
        ptw_req_valid |-> fill_valid && fill_dummy);

    // R6
    fill_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> !fault_valid);

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        miss_valid && miss_ready |=> !miss_ready);

    // R8
    fill_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> !fill_valid);

    // R3
    fill_bounds_chk: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> (fill_base <= va_q) && (va_q < fill_limit));

    // R7
    hop_limit_chk: assert property (@(posedge clk) disable iff (rst)
        hop_q <= HOP_W'(MAX_HOPS));

endmodule

// File: tb/tb_rtw_walker.sv
module tb_rtw_walker;
    localparam int ID_W = 4;
    localparam int MAXH = 8;
    localparam int NENT = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic             miss_valid = 1'b0;
    logic             miss_ready;
    logic [ID_W-1:0]  miss_id = '0;
    logic [63:0]      miss_va = '0;
    logic [63:0]      table_base = '0;
    logic             mem_req_valid;
    logic             mem_req_ready;
    logic [63:0]      mem_req_addr;
    logic             mem_rsp_valid;
    logic [63:0]      mem_rsp_data;
    logic             fill_valid;
    logic [ID_W-1:0]  fill_id;
    logic [63:0]      fill_base, fill_limit, fill_delta;
    logic [2:0]       fill_perm;
    logic             fill_dummy;
    logic             ptw_req_valid;
    logic [63:0]      ptw_req_va;
    logic             fault_valid;
    logic             fault_depth;
    logic [ID_W-1:0]  fault_id;
    logic [63:0]      fault_va;

    rtw_walker #(.ID_W(ID_W), .MAX_HOPS(MAXH)) dut (.*);

    int checks = 0;
    int fails  = 0;
    logic [63:0] tbl [NENT][4];
    int path [MAXH+1];
    int path_len = 0;
    int req_k = 0;
    logic [63:0] cur_base = '0;
    logic [1:0] stall = '0;
    logic prev_hold = 1'b0;
    logic [63:0] prev_addr = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] lo_of(int i);
        return 64'(i) * 64'h1000 + 64'h100;
    endfunction

    function automatic logic [63:0] mk_ctrl(int perm, bit dmy, bit last, int nxt);
        return 64'(perm & 7) | (64'(dmy) << 3) | (64'(last) << 4) | (64'(nxt & 15) << 16);
    endfunction

    task automatic load_table(input bit chained_forever);
        for (int i = 0; i < NENT; i++) begin
            tbl[i][0] = lo_of(i);
            tbl[i][1] = lo_of(i) + 64'h800;
            tbl[i][2] = 64'(i) * 64'h111 + 64'h4000_0000;
            tbl[i][3] = mk_ctrl(i % 8, (i % 3) == 0,
                                chained_forever ? 1'b0 : ((i % 4) == 3), (i + 1) % NENT);
        end
    endtask

    // kind: 0 fill, 1 chain-end fault, 2 hop-limit fault
    task automatic model(input int s, input logic [63:0] va, output int kind, output int lid);
        int id = s;
        int hops = 0;
        path_len = 0;
        forever begin
            path[path_len] = id;
            path_len++;
            if (tbl[id][0] <= va && va < tbl[id][1]) begin kind = 0; break; end
            if (tbl[id][3][4]) begin kind = 1; break; end
            if (hops == MAXH) begin kind = 2; break; end
            id = int'(tbl[id][3][19:16]);
            hops++;
        end
        lid = id;
    endtask

    // memory model
    assign mem_req_ready = (stall != 2'd2);
    always @(posedge clk) begin
        if (rst) begin
            stall         <= '0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
        end else begin
            stall         <= stall + 2'd1;
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                logic [63:0] off;
                logic [63:0] ea;
                off = mem_req_addr - cur_base;
                if (req_k / 4 < path_len)
                    ea = cur_base + (64'(path[req_k / 4]) << 5) + 64'((req_k % 4) * 8);
                else
                    ea = ~mem_req_addr;
                // R1 R2: address sequence from the captured base
                chk(mem_req_addr == ea, "R1 R2 request address", mem_req_addr, ea);
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= tbl[off[8:5]][off[4:3]];
                req_k++;
            end
        end
    end

    // R10 hold monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_hold)
                chk(mem_req_valid && mem_req_addr == prev_addr, "R10 request held",
                    mem_req_addr, prev_addr);
            prev_hold <= mem_req_valid && !mem_req_ready;
            prev_addr <= mem_req_addr;
        end
    end

    task automatic run_walk(input int s, input logic [63:0] va);
        int kind, lid, n;
        bit busy_bad;
        model(s, va, kind, lid);
        req_k = 0;
        @(negedge clk);
        chk(miss_ready, "R8 idle ready", 64'(miss_ready), 64'd1);
        miss_valid = 1'b1;
        miss_id    = ID_W'(s);
        miss_va    = va;
        table_base = cur_base;
        @(negedge clk);
        miss_valid = 1'b0;
        table_base = ~cur_base ^ 64'h5a5a;
        n = 0;
        busy_bad = 1'b0;
        while (!(fill_valid || fault_valid) && n < 3000) begin
            if (miss_ready) busy_bad = 1'b1;
            @(negedge clk);
            n++;
        end
        chk(!busy_bad, "R8 busy while walking", 64'(busy_bad), 64'd0);
        chk(miss_ready, "R8 ready with result", 64'(miss_ready), 64'd1);
        chk(req_k == 4 * path_len, "R1 R5 R7 request count", 64'(req_k), 64'(4 * path_len));
        if (kind == 0) begin
            // R3 fill contents
            chk(fill_valid && !fault_valid, "R3 fill", {fill_valid, fault_valid}, 64'd2);
            chk(fill_id == ID_W'(lid), "R3 R5 fill id", 64'(fill_id), 64'(lid));
            chk(fill_base == tbl[lid][0] && fill_limit == tbl[lid][1],
                "R3 bounds", fill_base, tbl[lid][0]);
            chk(fill_delta == tbl[lid][2], "R3 delta", fill_delta, tbl[lid][2]);
            chk(fill_perm == tbl[lid][3][2:0], "R3 perm", 64'(fill_perm), 64'(tbl[lid][3][2:0]));
            // R4 same-cycle lookup request
            chk(ptw_req_valid == tbl[lid][3][3] && fill_dummy == tbl[lid][3][3],
                "R4 lookup request", 64'(ptw_req_valid), 64'(tbl[lid][3][3]));
            if (tbl[lid][3][3])
                chk(ptw_req_va == va, "R4 lookup address", ptw_req_va, va);
        end else begin
            chk(fault_valid && !fill_valid && !ptw_req_valid, "R6 R7 fault only",
                {fault_valid, fill_valid, ptw_req_valid}, 64'd4);
            chk(fault_depth == (kind == 2), kind == 2 ? "R7 depth flag" : "R6 depth flag",
                64'(fault_depth), 64'(kind == 2));
            chk(fault_id == ID_W'(lid) && fault_va == va, "R6 fault id/va",
                64'(fault_id), 64'(lid));
        end
        @(negedge clk);
        chk(!fill_valid && !fault_valid && !ptw_req_valid, "R8 one-cycle pulse",
            {fill_valid, fault_valid, ptw_req_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        chk(miss_ready && !mem_req_valid && !fill_valid && !ptw_req_valid && !fault_valid,
            "R9 reset state", {miss_ready, mem_req_valid, fill_valid, ptw_req_valid, fault_valid},
            64'h10);

        // sweep 1: chains of four closed by chain-end flag
        load_table(1'b0);
        cur_base = 64'h0000_0040_0000_1000;
        for (int s = 0; s < NENT; s++) begin
            run_walk(s, lo_of(s) - 64'd1);
            for (int j = s; j <= (s | 3); j++) begin
                run_walk(s, tbl[j][0]);
                run_walk(s, tbl[j][1] - 64'd1);
                run_walk(s, tbl[j][1]);
            end
        end

        // sweep 2: unbroken ring, hop limit boundary
        load_table(1'b1);
        cur_base = 64'h0000_0000_0020_0000;
        for (int s = 0; s < NENT; s++) begin
            for (int t = 0; t < NENT; t++) run_walk(s, tbl[t][0] + 64'h7ff);
            run_walk(s, 64'hffff_0000_0000_0000);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule